// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit down counters behind a byte-wide register bus. Each channel has its own data address. A fourth address takes control words that set up one channel at a time. A control word either selects a channel's counting behaviour and byte-access pattern, or freezes the channel's current count so that software can read it without tearing. All channels advance only on clock cycles where the shared `tick_en` input is high. A typical system pulses that input once per 838 ns.

Three behaviours are supported:
- **One-shot terminal count.** The output goes high when the count runs out and stays high.
- **Periodic rate pulse.** The output drops for one tick per period.
- **Square wave.** The output toggles each half period.

Channel 0's output is the `irq0` interrupt request. Channel 2's output is visible in a small system status byte, and the low nibble of that byte is a plain software-writable register.

Top module: `interval_timer3`

## Requirements
- R1: After reset every channel is stopped with count 0 and output low, so `irq0` is 0 and `sys_status` is 0x00. A control word whose channel field (bits 7:6) is 3 changes nothing.
- R2: A control word with access field (bits 5:4) not equal to 0 sets the mode (bits 3:1) and clears the channel's count and reload, and stops the channel. Its output goes low for mode 0 and high for modes 2 and 3 on the next cycle.
- R3: Access field 1 reads and writes only the low byte. Field 2 reads and writes only the high byte. Field 3 alternates low then high, with separate toggles for reads and writes.
- R4: A control word with access field 0 captures the current count. The next two reads return its low and then high byte, and later reads show the live count starting with the low byte.
- R5: In mode 0, every data write drives the output low. In access 3 the channel waits for the high byte before loading and counting. For a reload N the output rises after N ticks and stays high while the count wraps.
- R6: In mode 2 the output is low exactly during the tick interval in which the count is 1. The count then reloads, so the period is N ticks. A reload of 0 or 1 counts as 65536.
- R7: In mode 3 each tick subtracts 2. When the count is 2 or 1 it reloads instead and the output toggles. A reload of 0 or 1 counts as 65536.
- R8: In modes 2 and 3, a reload written while the channel is running does not restart the count. It is used from the next reload on.
- R9: `irq0` follows channel 0's output. `sys_status` bit 5 is channel 2's output, bits 3:0 hold the last `sys_wdata` write, and the other bits read 0.
- R10: Counts change only on cycles where `tick_en` is high, or through a control or data write. A count loaded while `tick_en` stays low is unchanged when read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Shared count enable, one cycle per timer tick |
| bus_addr | input | 2 | 0..2 select a channel data port, 3 the control port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sys_wr | input | 1 | System status nibble write strobe |
| sys_wdata | input | 4 | System status nibble value |
| sys_status | output | 8 | {2'b00, channel 2 output, 1'b0, nibble} |
| irq0 | output | 1 | Channel 0 output as interrupt request |

## Verification
The hardest cases to reach are the ones where the byte sequencing and the counting interact. Examples are a reload written between the two byte halves, a reload written to a running periodic channel, and a count frozen by a latch while ticks continue. The stimulus builds each case by placing exact numbers of single-cycle ticks between bus writes, so the count at every read is known. Frozen counts are read after further ticks to show that the live value has moved on. The 65536 case is reached with a reload of 1 followed by a single tick, which makes the count wrap to 0xFFFF or 0xFFFE.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

  typedef enum logic [1:0] {
    KIND_TERM   = 2'd0,
    KIND_RATE   = 2'd1,
    KIND_SQUARE = 2'd2,
    KIND_IDLE   = 2'd3
  } tmr_kind_e;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_BOTH  = 2'd3
  } tmr_acc_e;

  function automatic tmr_kind_e decode_kind(input logic [2:0] m);
    case (m)
      3'd0:       return KIND_TERM;
      3'd2, 3'd6: return KIND_RATE;
      3'd3, 3'd7: return KIND_SQUARE;
      default:    return KIND_IDLE;
    endcase
  endfunction

  // a reload of 0 or 1 is stored as 0, which stands for the full 65536 range
  function automatic logic [15:0] period_of(input logic [15:0] r);
    return (r <= 16'd1) ? 16'd0 : r;
  endfunction

endpackage

// File: rtl/itimer_port.sv
module itimer_port
  import itimer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  tmr_acc_e          cfg_acc,
  input  logic              latch_cmd,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [CNT_W-1:0]  count,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              wr_done,
  output logic [DATA_W-1:0] rd_byte
);

  tmr_acc_e         acc_q;
  logic             wtog_q, rtog_q;
  logic [CNT_W-1:0] snap_q;
  logic             snap_full_q, snap_hi_q;

  assign wr_lo   = wr_stb && (acc_q == ACC_LO || (acc_q == ACC_BOTH && !wtog_q));
  assign wr_hi   = wr_stb && (acc_q == ACC_HI || (acc_q == ACC_BOTH && wtog_q));
  assign wr_done = wr_stb && (acc_q != ACC_BOTH || wtog_q);

  always_comb begin
    if (snap_full_q)
      rd_byte = snap_hi_q ? snap_q[CNT_W-1:DATA_W] : snap_q[DATA_W-1:0];
    else if (acc_q == ACC_HI || (acc_q == ACC_BOTH && rtog_q))
      rd_byte = count[CNT_W-1:DATA_W];
    else
      rd_byte = count[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q       <= ACC_BOTH;
      wtog_q      <= 1'b0;
      rtog_q      <= 1'b0;
      snap_q      <= '0;
      snap_full_q <= 1'b0;
      snap_hi_q   <= 1'b0;
    end else if (cfg_we) begin
      acc_q       <= cfg_acc;
      wtog_q      <= 1'b0;
      rtog_q      <= 1'b0;
      snap_full_q <= 1'b0;
      snap_hi_q   <= 1'b0;
    end else if (latch_cmd) begin
      snap_q      <= count;
      snap_full_q <= 1'b1;
      snap_hi_q   <= 1'b0;
      rtog_q      <= 1'b0;
    end else begin
      if (wr_stb && acc_q == ACC_BOTH) wtog_q <= ~wtog_q;
      if (rd_stb) begin
        if (snap_full_q) begin
          if (snap_hi_q) snap_full_q <= 1'b0;
          snap_hi_q <= ~snap_hi_q;
        end else if (acc_q == ACC_BOTH) begin
          rtog_q <= ~rtog_q;
        end
      end
    end
  end

  // a frozen count must not move while it is being read out
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
    (snap_full_q && !latch_cmd && !cfg_we) |=> (snap_q == $past(snap_q))) else $error("snap"); // R4

endmodule

// File: rtl/itimer_counter.sv
module itimer_counter
  import itimer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cfg_we,
  input  tmr_kind_e         cfg_kind,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_done,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count,
  output logic              out
);

  tmr_kind_e        kind_q;
  logic [CNT_W-1:0] reload_q, count_q, reload_nx, rate_nx;
  logic             run_q, out_q, wr_any;

  assign wr_any    = wr_lo || wr_hi;
  assign reload_nx = {wr_hi ? wdata : reload_q[CNT_W-1:DATA_W],
                      wr_lo ? wdata : reload_q[DATA_W-1:0]};
  assign rate_nx   = (count_q == CNT_W'(1)) ? period_of(reload_q) : count_q - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= KIND_TERM;
      reload_q <= '0;
      count_q  <= '0;
      run_q    <= 1'b0;
      out_q    <= 1'b0;
    end else if (cfg_we) begin
      kind_q   <= cfg_kind;
      reload_q <= '0;
      count_q  <= '0;
      run_q    <= 1'b0;
      out_q    <= (cfg_kind != KIND_TERM);
    end else if (wr_any) begin
      reload_q <= reload_nx;
      case (kind_q)
        KIND_TERM: begin
          out_q <= 1'b0;
          run_q <= wr_done;
          if (wr_done) count_q <= reload_nx;
        end
        KIND_RATE, KIND_SQUARE: begin
          if (!run_q && wr_done) begin
            count_q <= period_of(reload_nx);
            run_q   <= 1'b1;
          end
        end
        default: ;
      endcase
    end else if (tick && run_q) begin
      case (kind_q)
        KIND_TERM: begin
          count_q <= count_q - CNT_W'(1);
          if (count_q == CNT_W'(1)) out_q <= 1'b1;
        end
        KIND_RATE: begin
          count_q <= rate_nx;
          out_q   <= (rate_nx != CNT_W'(1));
        end
        KIND_SQUARE: begin
          if (count_q == CNT_W'(1) || count_q == CNT_W'(2)) begin
            count_q <= period_of(reload_q);
            out_q   <= ~out_q;
          end else begin
            count_q <= count_q - CNT_W'(2);
          end
        end
        default: ;
      endcase
    end
  end

  assign count = count_q;
  assign out   = out_q;

  AST_COUNT_GATED: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cfg_we && !wr_any) |=> (count_q == $past(count_q))) else $error("gate"); // R10
  AST_TERM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (kind_q == KIND_TERM && out_q && !cfg_we && !wr_any) |=> out_q) else $error("sticky"); // R5
  AST_RATE_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
    (kind_q == KIND_RATE && !out_q && tick && !cfg_we && !wr_any) |=> out_q) else $error("pulse"); // R6
  AST_MODESET_OUT: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_kind == KIND_TERM) |=> (!out_q && !run_q)) else $error("modeset"); // R2

endmodule

// File: rtl/itimer_channel.sv
module itimer_channel
  import itimer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cfg_we,
  input  tmr_acc_e          cfg_acc,
  input  tmr_kind_e         cfg_kind,
  input  logic              latch_cmd,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_byte,
  output logic              out
);

  logic [CNT_W-1:0] count;
  logic             wr_lo, wr_hi, wr_done;

  itimer_port #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_port (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_acc(cfg_acc),
    .latch_cmd(latch_cmd), .wr_stb(wr_stb), .rd_stb(rd_stb), .count(count),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_done(wr_done), .rd_byte(rd_byte)
  );

  itimer_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_done(wr_done), .wdata(wdata),
    .count(count), .out(out)
  );

endmodule

// File: rtl/interval_timer3.sv
module interval_timer3
  import itimer_pkg::*;
#(
  parameter int CH_COUNT  = 3,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 16,
  parameter int IRQ_CH    = 0,
  parameter int STATUS_CH = 2,
  parameter int NIB_W     = 4,
  localparam int ADDR_W   = $clog2(CH_COUNT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sys_wr,
  input  logic [NIB_W-1:0]  sys_wdata,
  output logic [DATA_W-1:0] sys_status,
  output logic              irq0
);

  logic              cw_wr, cw_unused;
  logic [1:0]        cw_ch;
  tmr_acc_e          cw_acc;
  tmr_kind_e         cw_kind;
  logic [DATA_W-1:0] rd_byte [CH_COUNT];
  logic [CH_COUNT-1:0] ch_out;
  logic [DATA_W-1:0] rd_sel;
  logic [NIB_W-1:0]  nib_q;

  assign cw_wr     = bus_wr && (int'(bus_addr) == CH_COUNT);
  assign cw_ch     = bus_wdata[7:6];
  assign cw_acc    = tmr_acc_e'(bus_wdata[5:4]);
  assign cw_kind   = decode_kind(bus_wdata[3:1]);
  assign cw_unused = bus_wdata[0];  // counting is binary only

  for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
    logic hit;
    assign hit = cw_wr && (int'(cw_ch) == g);
    itimer_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick_en),
      .cfg_we(hit && cw_acc != ACC_LATCH), .cfg_acc(cw_acc), .cfg_kind(cw_kind),
      .latch_cmd(hit && cw_acc == ACC_LATCH),
      .wr_stb(bus_wr && int'(bus_addr) == g), .rd_stb(bus_rd && int'(bus_addr) == g),
      .wdata(bus_wdata), .rd_byte(rd_byte[g]), .out(ch_out[g])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < CH_COUNT; i++)
      if (int'(bus_addr) == i) rd_sel = rd_byte[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      nib_q     <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_sel;
      if (sys_wr) nib_q <= sys_wdata;
    end
  end

  assign sys_status = {2'b00, ch_out[STATUS_CH], 1'b0, nib_q};
  assign irq0       = ch_out[IRQ_CH];

  AST_NIBBLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    sys_wr |=> (sys_status[NIB_W-1:0] == $past(sys_wdata))) else $error("nib"); // R9
  AST_STATUS_SPARE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sys_status[7:6] == 2'b00 && !sys_status[4])) else $error("spare"); // R9

endmodule

// File: tb/interval_timer3_tb.sv
module interval_timer3_tb;

  logic       clk = 0, rst = 1, tick_en = 0;
  logic [1:0] bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0, sys_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [3:0] sys_wdata = 0;
  logic [7:0] bus_rdata, sys_status;
  logic       irq0;

  int checks = 0, errors = 0;
  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  interval_timer3 u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_wr(sys_wr),
    .sys_wdata(sys_wdata), .sys_status(sys_status), .irq0(irq0)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_t x;
    x.exp = e; x.tag = tag;
    @(negedge clk); bus_addr = a; bus_rd = 1; sb.push_back(x);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tick_en = 1; end
    @(negedge clk); tick_en = 0;
  endtask

  task automatic sys_write(input logic [3:0] d);
    @(negedge clk); sys_wdata = d; sys_wr = 1;
    @(negedge clk); sys_wr = 0;
  endtask

  // monitor: pops the expected byte for each read once the data is registered
  initial forever begin
    @(posedge clk);
    if (bus_rd === 1'b1) begin
      @(negedge clk);
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual=%02h expected=none", bus_rdata);
      end else begin
        exp_t x;
        x = sb.pop_front();
        chk(bus_rdata, x.exp, x.tag);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({7'd0, irq0}, 8'h00, "R1 reset irq0");
    chk(sys_status, 8'h00, "R1 reset status");

    // channel 0, mode 0, both bytes
    wr(3, 8'h30);
    wr(0, 8'h05);
    tick(2);
    chk({7'd0, irq0}, 8'h00, "R5 waits for high byte");
    wr(0, 8'h00);
    tick(4);
    chk({7'd0, irq0}, 8'h00, "R5 before terminal");
    tick(1);
    chk({7'd0, irq0}, 8'h01, "R5 terminal count R9 irq0");
    tick(3);
    chk({7'd0, irq0}, 8'h01, "R5 stays high");
    rd_exp(0, 8'hFD, "R3 R5 wrap low byte");
    rd_exp(0, 8'hFF, "R3 R5 wrap high byte");
    wr(3, 8'h30);
    chk({7'd0, irq0}, 8'h00, "R2 mode0 set low");
    rd_exp(0, 8'h00, "R2 count cleared lo");
    rd_exp(0, 8'h00, "R2 count cleared hi");
    // low-only mode 0: reload write drops output
    wr(3, 8'h10);
    wr(0, 8'h02);
    tick(2);
    chk({7'd0, irq0}, 8'h01, "R5 lo-only terminal");
    wr(0, 8'h07);
    chk({7'd0, irq0}, 8'h00, "R5 write drives low");
    tick(6);
    chk({7'd0, irq0}, 8'h00, "R5 reloaded count");
    tick(1);
    chk({7'd0, irq0}, 8'h01, "R5 reloaded terminal");
    wr(3, 8'h34);
    chk({7'd0, irq0}, 8'h01, "R2 mode2 set high");

    // channel 2, mode 2, reload 4
    wr(3, 8'hB4);
    chk(sys_status, 8'h20, "R2 R9 ch2 high after set");
    wr(2, 8'h04); wr(2, 8'h00);
    tick(2);
    chk(sys_status, 8'h20, "R6 high count 2");
    tick(1);
    chk(sys_status, 8'h00, "R6 low at count 1");
    tick(1);
    chk(sys_status, 8'h20, "R6 high after reload");
    wr(2, 8'h06); wr(2, 8'h00);
    wr(3, 8'h80);
    rd_exp(2, 8'h04, "R8 no restart lo");
    rd_exp(2, 8'h00, "R8 no restart hi");
    tick(3);
    chk(sys_status, 8'h00, "R8 old period ends");
    tick(1);
    chk(sys_status, 8'h20, "R8 reload taken");
    tick(4);
    chk(sys_status, 8'h20, "R8 new period mid");
    tick(1);
    chk(sys_status, 8'h00, "R8 new period of 6");

    // channel 2, mode 3, reload 8
    wr(3, 8'hB6);
    wr(2, 8'h08); wr(2, 8'h00);
    tick(3);
    chk(sys_status, 8'h20, "R7 first half");
    tick(1);
    chk(sys_status, 8'h00, "R7 toggle low");
    tick(3);
    chk(sys_status, 8'h00, "R7 second half");
    tick(1);
    chk(sys_status, 8'h20, "R7 toggle high");
    wr(3, 8'hB6);
    wr(2, 8'h01); wr(2, 8'h00);
    tick(1);
    wr(3, 8'h80);
    rd_exp(2, 8'hFE, "R7 65536 lo");
    rd_exp(2, 8'hFF, "R7 65536 hi");

    // channel 1, mode 2: idle gating and latch
    wr(3, 8'h74);
    wr(1, 8'h0A); wr(1, 8'h00);
    repeat (30) @(negedge clk);
    rd_exp(1, 8'h0A, "R10 idle lo");
    rd_exp(1, 8'h00, "R10 idle hi");
    tick(3);
    wr(3, 8'h40);
    tick(2);
    rd_exp(1, 8'h07, "R4 latched lo");
    rd_exp(1, 8'h00, "R4 latched hi");
    rd_exp(1, 8'h05, "R4 live lo");
    rd_exp(1, 8'h00, "R4 live hi");
    wr(3, 8'h74);
    wr(1, 8'h01); wr(1, 8'h00);
    tick(1);
    rd_exp(1, 8'hFF, "R6 65536 lo");
    rd_exp(1, 8'hFF, "R6 65536 hi");

    // byte access patterns
    wr(3, 8'h54);
    wr(1, 8'h03);
    rd_exp(1, 8'h03, "R3 lo-only read");
    rd_exp(1, 8'h03, "R3 lo-only no toggle");
    tick(1);
    rd_exp(1, 8'h02, "R3 lo-only after tick");
    wr(3, 8'h64);
    wr(1, 8'h02);
    rd_exp(1, 8'h02, "R3 hi-only read");
    tick(1);
    rd_exp(1, 8'h01, "R3 hi-only after tick");
    wr(3, 8'hF4);
    rd_exp(1, 8'h01, "R1 channel 3 ignored");

    // status nibble
    sys_write(4'hF);
    chk(sys_status, 8'h2F, "R9 nibble set");
    sys_write(4'h5);
    chk(sys_status, 8'h25, "R9 nibble rewrite");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule